// File: doc/BRIEF.md
# Alternating Push-Pull PWM Generator

This block produces the two gate-drive signals of a half-bridge or push-pull power stage from a single edge-aligned counter and a single duty value. Every PWM period yields exactly one pulse. A steering flip-flop that toggles at each period rollover routes the pulse to output A in one period and to output B in the next, so the two switches always receive pulses of identical width and are never driven together.

A cycle-by-cycle current limit is supported through an asynchronous comparator trip input. Once synchronized, a trip cuts the running pulse short and keeps the output low until the period ends. The following period starts a fresh pulse on the other output with no external help. The duty value can be applied at once, or held in a shadow register and transferred at the next rollover so that a change never produces a malformed pulse.

Top module: `alt_pwm_top`

## Requirements
- R1: With enable high, the internal count runs 0, 1, ..., period_i-1 and wraps to 0, so one PWM period lasts period_i clock cycles (period_i of at least 2).
- R2: The pulse is high while the count is below the active compare value. In a period whose phase_o is 0 the pulse appears on out_a_o and out_b_o stays low; when phase_o is 1 it appears on out_b_o and out_a_o stays low.
- R3: phase_o toggles at every rollover, so consecutive periods carry pulses on A and B in turn, each with the same width taken from one compare value.
- R4: A compare value of 0 gives no pulse. A compare value equal to or above period_i is clamped to period_i-1, so the last count of every period is always low.
- R5: out_a_o and out_b_o are never high in the same cycle nor in two consecutive cycles. err_o is high whenever both outputs are high together, so it stays 0 in operation.
- R6: While en_i is low, both outputs are low, the count is held at 0 and phase_o returns to 0. After en_i rises, the first pulse goes to out_a_o, starting in the first enabled cycle.
- R7: trip_i passes through a two-flop synchronizer. Once it has been synchronized, the active pulse ends, and the output stays low for the rest of that period even if trip_i falls again.
- R8: The trip latch clears at the rollover. The next period produces a full-width pulse on the other output.
- R9: With preload_i high, a duty_i value written through duty_wr_i is held in a shadow register. It becomes the active compare value only at the next rollover, so the current period keeps its width.
- R10: With preload_i low, a write through duty_wr_i becomes the active compare value on the following clock cycle.
- R11: upd_o is high for exactly one cycle per period, during the last count (period_i-1), and never while en_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the generator idle |
| period_i | input | CNT_W | Period length in clock cycles |
| duty_i | input | CNT_W | Duty value to be written |
| duty_wr_i | input | 1 | Write strobe for duty_i |
| preload_i | input | 1 | 1: duty write waits for rollover; 0: takes effect at once |
| trip_i | input | 1 | Asynchronous comparator trip, active high |
| out_a_o | output | 1 | Gate drive A |
| out_b_o | output | 1 | Gate drive B |
| phase_o | output | 1 | Current period owner: 0 = A, 1 = B |
| upd_o | output | 1 | Rollover strobe, high in the last cycle of each period |
| err_o | output | 1 | High if A and B are high in the same cycle |

## Verification
If the steering flip-flop ends up in the wrong state, the pulse lands on the wrong output, and this is visible in the first enabled period or at the next rollover. A stale trip latch or a compare register with the wrong value changes the measured pulse width inside that same period. A shadow register transferred at the wrong moment changes the width one period early or one period late. The bench therefore counts the high cycles of each output over every period and checks where upd_o falls, so any such fault shows up within at most two periods.

// File: rtl/alt_pwm_pkg.sv
package alt_pwm_pkg;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    typedef struct packed {
        logic meta;
        logic sync;
        logic held;
    } trip_st_t;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             roll_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tb_st_t;

    tb_st_t st_d, st_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        last   = (period_i <= ONE) ? '0 : period_i - ONE;
        roll_o = en_i && (st_q.cnt >= last);
        st_d   = st_q;
        if (!en_i || roll_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R1
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !roll_o) |=> (st_q.cnt == $past(st_q.cnt) + ONE));

endmodule

// File: rtl/pwm_duty.sv
module pwm_duty #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             duty_wr_i,
    input  logic             preload_i,
    input  logic             roll_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             req_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] cmp;
    } duty_st_t;

    duty_st_t st_d, st_q;
    logic [CNT_W-1:0] cmp_eff;
    logic [CNT_W-1:0] last;

    always_comb begin
        st_d = st_q;
        if (duty_wr_i) begin
            st_d.shadow = duty_i;
            if (!preload_i) begin
                st_d.cmp = duty_i;
            end
        end
        if (preload_i && roll_i) begin
            st_d.cmp = duty_wr_i ? duty_i : st_q.shadow;
        end
        last    = (period_i <= ONE) ? '0 : period_i - ONE;
        cmp_eff = (st_q.cmp >= period_i) ? last : st_q.cmp;
        req_o   = cnt_i < cmp_eff;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    preload_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (preload_i && !roll_i) |=> $stable(st_q.cmp));

    // R10
    direct_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (duty_wr_i && !preload_i) |=> (st_q.cmp == $past(duty_i)));

    // R4
    last_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        roll_i |-> !req_o);

endmodule

// File: rtl/pwm_trip.sv
module pwm_trip (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic trip_i,
    input  logic roll_i,
    output logic block_o
);
    import alt_pwm_pkg::*;

    trip_st_t st_d, st_q;

    always_comb begin
        st_d.meta = trip_i;
        st_d.sync = st_q.meta;
        if (!en_i || roll_i) begin
            st_d.held = 1'b0;
        end else begin
            st_d.held = st_q.held | st_q.sync;
        end
        block_o = st_q.sync | st_q.held;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    trip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && st_q.sync && !roll_i) |=> block_o);

endmodule

// File: rtl/alt_pwm_top.sv
module alt_pwm_top #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic             duty_wr_i,
    input  logic             preload_i,
    input  logic             trip_i,
    output logic             out_a_o,
    output logic             out_b_o,
    output logic             phase_o,
    output logic             upd_o,
    output logic             err_o
);
    import alt_pwm_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic             roll;
    logic             req;
    logic             blk;
    logic             pulse;
    phase_e           phase_d, phase_q;

    pwm_timebase #(.CNT_W(CNT_W)) i_timebase (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (en_i),
        .period_i (period_i),
        .cnt_o    (cnt),
        .roll_o   (roll)
    );

    pwm_duty #(.CNT_W(CNT_W)) i_duty (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .period_i  (period_i),
        .duty_i    (duty_i),
        .duty_wr_i (duty_wr_i),
        .preload_i (preload_i),
        .roll_i    (roll),
        .cnt_i     (cnt),
        .req_o     (req)
    );

    pwm_trip i_trip (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .trip_i  (trip_i),
        .roll_i  (roll),
        .block_o (blk)
    );

    always_comb begin
        phase_d = phase_q;
        if (!en_i) begin
            phase_d = PH_A;
        end else if (roll) begin
            phase_d = (phase_q == PH_A) ? PH_B : PH_A;
        end
        pulse   = en_i && req && !blk;
        out_a_o = pulse && (phase_q == PH_A);
        out_b_o = pulse && (phase_q == PH_B);
        err_o   = out_a_o && out_b_o;
        phase_o = phase_q;
        upd_o   = roll;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= PH_A;
        end else begin
            phase_q <= phase_d;
        end
    end

    // R3
    phase_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_o |=> (phase_o != $past(phase_o)));

    // R5
    a_then_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_a_o |=> !out_b_o);

    // R5
    b_then_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_b_o |=> !out_a_o);

    // R6
    idle_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (phase_o == PH_A));

    // R7
    trip_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blk |-> (!out_a_o && !out_b_o));

endmodule

// File: tb/test_alt_pwm_top.sv
module test_alt_pwm_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] period = 8'd10;
    logic [W-1:0] duty = '0;
    logic         wr = 1'b0;
    logic         pre = 1'b0;
    logic         trip = 1'b0;
    logic         out_a, out_b, phase, upd, err;

    int n_chk = 0;
    int n_fail = 0;
    int overlap_seen = 0;

    always #5 clk = ~clk;

    alt_pwm_top #(.CNT_W(W)) i_alt_pwm_top (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .en_i      (en),
        .period_i  (period),
        .duty_i    (duty),
        .duty_wr_i (wr),
        .preload_i (pre),
        .trip_i    (trip),
        .out_a_o   (out_a),
        .out_b_o   (out_b),
        .phase_o   (phase),
        .upd_o     (upd),
        .err_o     (err)
    );

    // period, duty, expected width
    localparam logic [23:0] VEC [9] = '{
        {8'd10,  8'd3,   8'd3},
        {8'd10,  8'd0,   8'd0},
        {8'd10,  8'd10,  8'd9},
        {8'd10,  8'd25,  8'd9},
        {8'd16,  8'd1,   8'd1},
        {8'd16,  8'd15,  8'd15},
        {8'd4,   8'd2,   8'd2},
        {8'd100, 8'd1,   8'd1},
        {8'd100, 8'd99,  8'd99}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && ((out_a && out_b) || err)) overlap_seen++;
    end

    task automatic setup(input int p, input int d, input bit preload);
        en = 1'b0;
        period = W'(p);
        duty = W'(d);
        pre = 1'b0;
        wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        pre = preload;
        en = 1'b1;
    endtask

    task automatic run_period(input int p, input int t_set, input int t_clr,
                              input int w_at, input int w_val,
                              output int ca, output int cb,
                              output int nupd, output int upd_at);
        ca = 0; cb = 0; nupd = 0; upd_at = -1;
        for (int i = 0; i < p; i++) begin
            #1;
            if (out_a) ca++;
            if (out_b) cb++;
            if (upd) begin nupd++; upd_at = i; end
            if (i == t_set) trip = 1'b1;
            if (i == t_clr) trip = 1'b0;
            if (i == w_at) begin duty = W'(w_val); wr = 1'b1; end
            else wr = 1'b0;
            @(negedge clk);
        end
        wr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int ca, cb, nu, ua;
        @(negedge clk);
        #1;
        // R6 reset state
        check(!out_a && !out_b && !upd && !phase && !err, "R6 reset outputs",
              {out_a, out_b, upd, phase, err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 R2 R3 R4 R11
        for (int v = 0; v < 9; v++) begin
            int p, e;
            p = int'(VEC[v][23:16]);
            e = int'(VEC[v][7:0]);
            setup(p, int'(VEC[v][15:8]), 1'b0);
            run_period(p, -1, -1, -1, 0, ca, cb, nu, ua);
            check(ca == e, $sformatf("R2 R4 vec%0d A width", v), ca, e);
            check(cb == 0, $sformatf("R2 vec%0d B idle", v), cb, 0);
            check(nu == 1 && ua == p - 1, $sformatf("R1 R11 vec%0d upd pos", v), ua, p - 1);
            run_period(p, -1, -1, -1, 0, ca, cb, nu, ua);
            check(cb == e, $sformatf("R3 vec%0d B width", v), cb, e);
            check(ca == 0, $sformatf("R3 vec%0d A idle", v), ca, 0);
            check(nu == 1 && ua == p - 1, $sformatf("R11 vec%0d upd pos2", v), ua, p - 1);
        end

        // R6 disabled: nothing moves
        setup(10, 5, 1'b0);
        en = 1'b0;
        run_period(20, -1, -1, -1, 0, ca, cb, nu, ua);
        check(ca + cb == 0, "R6 disabled outputs", ca + cb, 0);
        check(nu == 0, "R11 no upd while disabled", nu, 0);
        #1;
        check(phase == 1'b0, "R6 phase idle", phase, 0);

        // R7 trip cuts pulse, R8 restart on B
        setup(20, 15, 1'b0);
        run_period(20, 4, 8, -1, 0, ca, cb, nu, ua);
        check(ca == 6, "R7 tripped A width", ca, 6);
        check(cb == 0, "R7 B idle during trip", cb, 0);
        run_period(20, -1, -1, -1, 0, ca, cb, nu, ua);
        check(cb == 15, "R8 B full width after trip", cb, 15);
        check(ca == 0, "R8 A idle next period", ca, 0);

        // R9 preload holds write until rollover
        setup(10, 3, 1'b1);
        run_period(10, -1, -1, 2, 7, ca, cb, nu, ua);
        check(ca == 3, "R9 current width kept", ca, 3);
        run_period(10, -1, -1, -1, 0, ca, cb, nu, ua);
        check(cb == 7, "R9 new width after rollover", cb, 7);

        // R10 immediate write
        setup(10, 2, 1'b0);
        run_period(10, -1, -1, 1, 6, ca, cb, nu, ua);
        check(ca == 6, "R10 immediate width", ca, 6);
        run_period(10, -1, -1, -1, 0, ca, cb, nu, ua);
        check(cb == 6, "R10 next period width", cb, 6);

        // R5 overlap never observed
        check(overlap_seen == 0, "R5 overlap count", overlap_seen, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule